// File: doc/BRIEF.md
# EAC Single-Channel Texel Decoder

This block recovers one texel value from a 64-bit block of the EAC single-channel compression scheme. A caller presents the block as it sits in memory, the texel's column and row inside the 4x4 tile, and a mode code. One clock later the block returns a signed 12-bit integer on the scale of the selected mode. There are three scales: 8-bit alpha (0..255), unsigned 11-bit (0..2047) and signed 11-bit (-1023..1023).

Each block carries an 8-bit base value, a 4-bit scale factor, a 4-bit selector into a 16-row table of modifier magnitudes, and one 3-bit code per texel. The decoder turns the code into a signed modifier, multiplies it by the effective scale, adds the effective base and clamps the sum. Two-channel red/green data needs two instances, one fed with each 64-bit half of the 128-bit block. Conversion to a normalised float is left to the consumer.

Top module: `eac_texel_decoder`

## Requirements
- R1: `in_blk[7:0]` (the first byte in memory) is the base value. Bits `in_blk[15:12]` are the scale factor and `in_blk[11:8]` are the table row.
- R2: Form a 64-bit word L. Its upper 32 bits are `in_blk[31:0]` with byte order reversed, and its lower 32 bits are `in_blk[63:32]` with byte order reversed. The texel at column x and row y has linear number n = 4*x + y, and its 3-bit code is L[45-3n+2 : 45-3n].
- R3: Table rows in hex, row 0 first: e852, c962, c741, c531, b752, a862, a763, a742, 9751, 9741, 9731, 9641, 9632, 9210, 8753, 8642. Code bits [1:0] pick the nibble at bit 4*k of the row. Code bit 2 set gives modifier +nibble; bit 2 clear gives -(nibble+1).
- R4: Mode code 0 (8-bit alpha) gives base + modifier*scale, clamped to 0..255.
- R5: Mode code 1 (unsigned 11-bit) uses base*8+4 as base and max(scale*8, 1) as multiplier, and clamps to 0..2047.
- R6: Mode code 2 (signed 11-bit) uses the base byte as a two's-complement value times 8, and max(scale*8, 1) as multiplier. It clamps to -1023..1023.
- R7: Mode code 3 decodes exactly as mode code 0.
- R8: `out_valid` is high in the cycle after an edge that samples `in_valid` high, and low in the cycle after an edge that samples it low. `out_texel` then holds the result for the inputs sampled at that edge.
- R9: While `in_valid` is low, `out_texel` holds its value and ignores every other input.
- R10: Synchronous reset drives `out_valid` and `out_texel` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a request this cycle |
| in_mode | input | 2 | Output scale: 0 alpha8, 1 unsigned 11, 2 signed 11, 3 as 0 |
| in_blk | input | 64 | Compressed block, memory byte 0 in bits 7:0 |
| in_x | input | 2 | Texel column in the tile |
| in_y | input | 2 | Texel row in the tile |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_texel | output | 12 | Signed decoded texel value |

## Verification
The bench builds the decoder with its default parameters: a 64-bit block, a 14-bit signed intermediate and a 12-bit result. This shape is small enough to cover every mode code, every table row, every scale factor and every 3-bit code, each against six base bytes that include 0, 127, 128 and 255. Those bases reach both clamp limits of every mode and the sign change in signed mode. A separate pass decodes all sixteen texel positions from blocks with mixed codes, to confirm bit addressing across the half-word seam.

// File: rtl/eac_pkg.sv
package eac_pkg;

  typedef enum logic [1:0] {
    EAC_MODE_A8  = 2'd0,
    EAC_MODE_U11 = 2'd1,
    EAC_MODE_S11 = 2'd2,
    EAC_MODE_ALT = 2'd3
  } eac_mode_e;

  typedef struct packed {
    logic [7:0] base;
    logic [3:0] scale;
    logic [3:0] row;
    logic [2:0] code;
  } eac_fields_t;

endpackage

// File: rtl/eac_field_unpack.sv
module eac_field_unpack
  import eac_pkg::*;
#(
  parameter int BLK_W = 64,
  parameter int POS_W = 2
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [POS_W-1:0] px,
  input  logic [POS_W-1:0] py,
  output eac_fields_t      fields
);
  localparam int HALF_W  = BLK_W / 2;
  localparam int BYTES   = HALF_W / 8;
  localparam int HDR_W   = 16;
  localparam int CODE_W  = 3;
  localparam int IDX_W   = BLK_W - HDR_W;
  localparam int TOP_OFF = IDX_W - CODE_W;
  localparam int OFF_W   = $clog2(BLK_W);

  logic [BLK_W-1:0] swapped;
  logic [BLK_W-1:0] word;
  logic [OFF_W-1:0] off;

  // reverse the byte order inside each 32-bit half
  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign swapped[h*HALF_W + b*8 +: 8] = blk[h*HALF_W + (BYTES-1-b)*8 +: 8];
    end
  end

  // lower memory half becomes the most significant word
  assign word = {swapped[HALF_W-1:0], swapped[BLK_W-1:HALF_W]};

  always_comb begin
    off         = OFF_W'(TOP_OFF - CODE_W * int'({px, py}));
    fields.base  = word[BLK_W-1 -: 8];
    fields.scale = word[BLK_W-9 -: 4];
    fields.row   = word[BLK_W-13 -: 4];
    fields.code  = word[off +: CODE_W];
  end

endmodule

// File: rtl/eac_modifier.sv
module eac_modifier (
  input  logic [3:0]        row,
  input  logic [2:0]        code,
  output logic signed [4:0] modv
);
  logic [15:0] packed_row;
  logic [3:0]  mag;

  always_comb begin
    unique case (row)
      4'd0:  packed_row = 16'he852;
      4'd1:  packed_row = 16'hc962;
      4'd2:  packed_row = 16'hc741;
      4'd3:  packed_row = 16'hc531;
      4'd4:  packed_row = 16'hb752;
      4'd5:  packed_row = 16'ha862;
      4'd6:  packed_row = 16'ha763;
      4'd7:  packed_row = 16'ha742;
      4'd8:  packed_row = 16'h9751;
      4'd9:  packed_row = 16'h9741;
      4'd10: packed_row = 16'h9731;
      4'd11: packed_row = 16'h9641;
      4'd12: packed_row = 16'h9632;
      4'd13: packed_row = 16'h9210;
      4'd14: packed_row = 16'h8753;
      default: packed_row = 16'h8642;
    endcase
    mag = packed_row[{code[1:0], 2'b00} +: 4];
    // inverting the zero-extended magnitude yields -(mag+1)
    modv = code[2] ? $signed({1'b0, mag}) : $signed(~{1'b0, mag});
  end

endmodule

// File: rtl/eac_scale_clamp.sv
module eac_scale_clamp
  import eac_pkg::*;
#(
  parameter int INT_W = 14,
  parameter int OUT_W = 12
) (
  input  eac_mode_e                mode,
  input  logic [7:0]               base,
  input  logic [3:0]               scale,
  input  logic signed [4:0]        modv,
  output logic signed [OUT_W-1:0]  value
);
  localparam int A8_MAX  = 255;
  localparam int U11_MAX = 2047;
  localparam int S11_LIM = 1023;

  logic signed [INT_W-1:0] eff_base, eff_mult, sum, lo, hi;
  logic signed [INT_W-1:0] mod_ext;

  always_comb begin
    mod_ext = INT_W'(modv);
    unique case (mode)
      EAC_MODE_U11: begin
        eff_base = INT_W'({base, 3'b100});
        eff_mult = (scale == 4'd0) ? INT_W'(1) : INT_W'({scale, 3'b000});
        lo       = '0;
        hi       = INT_W'(U11_MAX);
      end
      EAC_MODE_S11: begin
        eff_base = INT_W'($signed({base, 3'b000}));
        eff_mult = (scale == 4'd0) ? INT_W'(1) : INT_W'({scale, 3'b000});
        lo       = -INT_W'(S11_LIM);
        hi       = INT_W'(S11_LIM);
      end
      default: begin
        eff_base = INT_W'(base);
        eff_mult = INT_W'(scale);
        lo       = '0;
        hi       = INT_W'(A8_MAX);
      end
    endcase
    sum = eff_base + mod_ext * eff_mult;
    if (sum < lo)      value = OUT_W'(lo);
    else if (sum > hi) value = OUT_W'(hi);
    else               value = OUT_W'(sum);
  end

endmodule

// File: rtl/eac_texel_decoder.sv
module eac_texel_decoder
  import eac_pkg::*;
#(
  parameter int BLK_W = 64,
  parameter int POS_W = 2,
  parameter int INT_W = 14,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              in_mode,
  input  logic [BLK_W-1:0]        in_blk,
  input  logic [POS_W-1:0]        in_x,
  input  logic [POS_W-1:0]        in_y,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_texel
);
  eac_fields_t             fields;
  logic signed [4:0]       modv;
  logic signed [OUT_W-1:0] texel_d;
  eac_mode_e               mode_q;

  eac_field_unpack #(.BLK_W(BLK_W), .POS_W(POS_W)) u_unpack (
    .blk(in_blk), .px(in_x), .py(in_y), .fields(fields)
  );

  eac_modifier u_mod (
    .row(fields.row), .code(fields.code), .modv(modv)
  );

  eac_scale_clamp #(.INT_W(INT_W), .OUT_W(OUT_W)) u_scale (
    .mode(eac_mode_e'(in_mode)), .base(fields.base), .scale(fields.scale),
    .modv(modv), .value(texel_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_texel <= '0;
      mode_q    <= EAC_MODE_A8;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_texel <= texel_d;
        mode_q    <= eac_mode_e'(in_mode);
      end
    end
  end

  p_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_texel));
  p_a8_range_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == EAC_MODE_A8 || mode_q == EAC_MODE_ALT))
      |-> (out_texel >= 0 && out_texel <= 255));
  p_u11_range_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == EAC_MODE_U11) |-> (out_texel >= 0 && out_texel <= 2047));
  p_s11_range_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == EAC_MODE_S11) |-> (out_texel >= -1023 && out_texel <= 1023));

endmodule

// File: tb/eac_texel_decoder_test.sv
`timescale 1ns/100ps
module eac_texel_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic [63:0] in_blk;
  logic [1:0]  in_x, in_y;
  logic        out_valid;
  logic signed [11:0] out_texel;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  eac_texel_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_blk(in_blk),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_texel(out_texel)
  );

  localparam logic [15:0] ROWS [16] = '{16'he852, 16'hc962, 16'hc741, 16'hc531,
    16'hb752, 16'ha862, 16'ha763, 16'ha742, 16'h9751, 16'h9741, 16'h9731, 16'h9641,
    16'h9632, 16'h9210, 16'h8753, 16'h8642};
  localparam int BASES [6] = '{0, 1, 100, 127, 128, 255};

  function automatic logic [31:0] rev32(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // L = {base, scale, row, 48 code bits}; texel n code at L[45-3n +: 3]
  function automatic logic [63:0] pack_blk(int base, int scale, int row, logic [47:0] codes);
    logic [63:0] l;
    l = {base[7:0], scale[3:0], row[3:0], codes};
    return {rev32(l[31:0]), rev32(l[63:32])};
  endfunction

  function automatic int expect_val(int mode, int base, int scale, int row, int code);
    int mag, m, b, mul, lo, hi, s;
    mag = (ROWS[row] >> (4 * (code % 4))) & 15;
    m   = (code >= 4) ? mag : -mag - 1;
    if (mode == 1) begin
      b = base * 8 + 4; mul = (scale == 0) ? 1 : scale * 8; lo = 0; hi = 2047;
    end else if (mode == 2) begin
      b = ((base >= 128) ? base - 256 : base) * 8; mul = (scale == 0) ? 1 : scale * 8;
      lo = -1023; hi = 1023;
    end else begin
      b = base; mul = scale; lo = 0; hi = 255;
    end
    s = b + m * mul;
    if (s < lo) s = lo;
    if (s > hi) s = hi;
    return s;
  endfunction

  function automatic logic [47:0] fill_codes(int target, int code);
    logic [47:0] c;
    for (int n = 0; n < 16; n++)
      c[45 - 3*n +: 3] = (n == target) ? code[2:0] : ~code[2:0];
    return c;
  endfunction

  // called right after a negedge; result sampled at the following negedge
  task automatic run_one(int mode, logic [63:0] blk, int tx, int ty, int exp, string req);
    in_valid = 1'b1; in_mode = mode[1:0]; in_blk = blk; in_x = tx[1:0]; in_y = ty[1:0];
    @(negedge clk);
    tests++;
    if (!out_valid || int'(out_texel) != exp) begin
      fails++;
      $display("FAIL %s: mode %0d got valid=%0b texel=%0d, expected valid=1 texel=%0d",
               req, mode, out_valid, out_texel, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] blk;
    logic signed [11:0] held;
    int tgt;
    string req;
    rst = 1'b1; in_valid = 1'b1; in_mode = 2'd0; in_blk = '1; in_x = 2'd3; in_y = 2'd3;
    repeat (3) @(negedge clk);
    tests++;  // R10 reset state
    if (out_valid !== 1'b0 || out_texel !== 12'sd0) begin
      fails++;
      $display("FAIL R10: got valid=%0b texel=%0d, expected valid=0 texel=0", out_valid, out_texel);
    end
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    // R1 byte placement: base 0x5a, scale 3, row 6, texel (1,2) code 5
    blk = pack_blk(8'h5a, 3, 6, fill_codes(6, 5));
    run_one(0, blk, 1, 2, expect_val(0, 8'h5a, 3, 6, 5), "R1");

    // R3 table and sign: unsigned mode, scale 1 avoids clamp
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        run_one(1, pack_blk(128, 1, r, fill_codes(r, c)), r / 4, r % 4,
                expect_val(1, 128, 1, r, c), "R3");

    // R4..R7 sweep over modes, rows, scales, codes and bases
    for (int md = 0; md < 4; md++) begin
      req = (md == 0) ? "R4" : (md == 1) ? "R5" : (md == 2) ? "R6" : "R7";
      for (int r = 0; r < 16; r++)
        for (int s = 0; s < 16; s++)
          for (int c = 0; c < 8; c++)
            for (int bi = 0; bi < 6; bi++) begin
              tgt = (r + s + c + bi) % 16;
              run_one(md, pack_blk(BASES[bi], s, r, fill_codes(tgt, c)), tgt / 4, tgt % 4,
                      expect_val(md, BASES[bi], s, r, c), req);
            end
    end

    // R2 every texel position, mixed codes
    for (int k = 0; k < 4; k++) begin
      logic [47:0] codes;
      for (int n = 0; n < 16; n++) codes[45 - 3*n +: 3] = 3'((n * 5 + k * 3 + 1) % 8);
      for (int n = 0; n < 16; n++)
        run_one(1, pack_blk(90 + k * 30, 5, k * 4 + 1, codes), n / 4, n % 4,
                expect_val(1, 90 + k * 30, 5, k * 4 + 1, (n * 5 + k * 3 + 1) % 8), "R2");
    end

    // R8/R9: drop valid, disturb inputs, output must hold
    held = out_texel;
    in_valid = 1'b0; in_mode = 2'd2; in_blk = 64'h0123_4567_89ab_cdef; in_x = 2'd0; in_y = 2'd1;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8: got valid=%0b, expected valid=0", out_valid);
    end
    repeat (3) @(negedge clk);
    tests++;
    if (out_texel !== held) begin
      fails++;
      $display("FAIL R9: got texel=%0d, expected texel=%0d", out_texel, held);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule